// File: doc/BRIEF.md
# Store/Recall Command Sequence Detector

This block sits beside a nonvolatile-backed static memory and watches the bus cycles that the host makes. A front end gives it one event for each cycle that chip enable qualifies. Each event carries the 15-bit address and the level of the active-low write strobe. The detector looks for one fixed run of six read cycles. The first five addresses are always the same. The sixth address chooses the command: one value asks the backup controller to copy the array into nonvolatile storage (store), and another asks it to copy nonvolatile storage back into the array (recall). A write, or a read that is off the sequence, drops the run that is under way. The block raises no command in that case.

Cycle events arrive on a valid/ready pair. The detector accepts an event in any clock where `cyc_valid` and `cyc_ready` are both high. When it issues a command, it drops `cyc_ready` and keeps it low until the backup controller returns `op_done`. This models a device that is disabled while the nonvolatile operation runs. The detector does not buffer events that are offered while ready is low. Those cycles are simply not taken, and they have no effect on the match position or on the command outputs. The source is not required to hold them. A supply-low flag stops a completed store sequence from issuing a store, but it does not block a recall.

Top module: `nvseq_cmd_detect`

## Requirements
- R1: After reset, `match_pos` is 0, `store_cmd` and `recall_cmd` are low, and `cyc_ready` is high.
- R2: An accepted read whose compared address equals the expected prefix entry for the current position moves `match_pos` up by one in the next cycle. The prefix, from position 0 to position 4, is 0E38, 31C7, 03E0, 3C1F, 303F (hex).
- R3: Only address bits 13:0 are compared. The value of bit 14 has no effect on matching.
- R4: At position 5, an accepted read of 0FC0 with `supply_low` low gives a one-cycle `store_cmd` pulse in the next cycle, and `match_pos` goes to 0.
- R5: At position 5, an accepted read of 0C63 gives a one-cycle `recall_cmd` pulse in the next cycle, and `match_pos` goes to 0. `supply_low` does not affect this.
- R6: An accepted cycle with `cyc_we_n` low (a write) sets `match_pos` to 0 and issues no command, whatever its address is.
- R7: An accepted read that does not match the expected entry ends the run. If its address is 0E38, `match_pos` becomes 1. Otherwise it becomes 0, and no command is issued.
- R8: From the cycle in which a command pulse appears, `cyc_ready` is low. Events offered while ready is low change nothing. Ready returns high in the cycle after `op_done` is sampled high. When no command is pending, `op_done` has no effect.
- R9: When `supply_low` is high, a completed store sequence gives no `store_cmd`. `match_pos` goes to 0 and `cyc_ready` stays high.
- R10: `store_cmd` and `recall_cmd` are never high together, and neither one is high for two cycles in a row.
- R11: In a cycle with no accepted event, `match_pos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One chip-enable-qualified bus cycle is offered |
| cyc_ready | output | 1 | Detector can take a cycle (low while a command is pending) |
| cyc_addr | input | 15 | Address of the offered cycle |
| cyc_we_n | input | 1 | Write strobe level of the cycle (1 = read, 0 = write) |
| supply_low | input | 1 | Supply is below the switch level; blocks store commands |
| op_done | input | 1 | Backup controller has finished the commanded operation |
| store_cmd | output | 1 | One-cycle store request |
| recall_cmd | output | 1 | One-cycle recall request |
| match_pos | output | 3 | Number of sequence entries matched so far (0 to 5) |

## Verification
The assertions check several rules on every cycle. The position holds when no event is taken. A write always clears the run. A 0E38 read always leaves the position at 1. The two pulses never overlap and never repeat. The lock holds until `op_done`, and a command is never issued while the lock is held. A supply-low completion never produces a store. Other behaviour shows only in the bench scenarios, which are compared cycle by cycle with a behavioural model. These cover complete store and recall runs with bit 14 set on some addresses, aborts at several depths, idle gaps inside a run, and restarts right after a command. They also show that events offered during the lock are discarded, not deferred.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int ADDR_W  = 15;
  localparam int CMP_W   = 14;
  localparam int SEQ_LEN = 6;
  localparam int POS_W   = $clog2(SEQ_LEN);

  localparam logic [CMP_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [CMP_W-1:0] RECALL_KEY = 14'h0C63;

  // Expected compared address for each prefix position.
  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvseq_addr_match.sv
module nvseq_addr_match
  import nvseq_pkg::*;
#(
  parameter int KEY_W = CMP_W,
  parameter int N_SEQ = SEQ_LEN
) (
  input  logic [KEY_W-1:0] key,
  output logic [N_SEQ-2:0] prefix_hit,
  output logic             first_hit,
  output logic             store_hit,
  output logic             recall_hit
);
  for (genvar g = 0; g < N_SEQ - 1; g++) begin : g_prefix
    assign prefix_hit[g] = (key == KEY_W'(prefix_key(g)));
  end

  assign first_hit  = (key == KEY_W'(prefix_key(0)));
  assign store_hit  = (key == KEY_W'(STORE_KEY));
  assign recall_hit = (key == KEY_W'(RECALL_KEY));
endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
  import nvseq_pkg::*;
#(
  parameter int N_SEQ = SEQ_LEN,
  parameter int PW    = POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             is_read,
  input  logic [N_SEQ-2:0] prefix_hit,
  input  logic             first_hit,
  input  logic             store_hit,
  input  logic             recall_hit,
  input  logic             supply_low,
  output logic [PW-1:0]    pos,
  output logic             arm,
  output logic             store_q,
  output logic             recall_q
);
  localparam logic [PW-1:0] LAST = PW'(N_SEQ - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic          exp_hit;
  logic [PW-1:0] pos_nxt;
  logic          fire_st, fire_rc;

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < N_SEQ - 1; i++) begin
      if (pos == PW'(i)) exp_hit = prefix_hit[i];
    end
  end

  always_comb begin
    pos_nxt = pos;
    fire_st = 1'b0;
    fire_rc = 1'b0;
    if (take) begin
      if (!is_read) begin
        pos_nxt = '0;
      end else if (pos != LAST) begin
        if (exp_hit)        pos_nxt = pos + ONE;
        else if (first_hit) pos_nxt = ONE;
        else                pos_nxt = '0;
      end else begin
        if (store_hit && !supply_low) begin
          fire_st = 1'b1;
          pos_nxt = '0;
        end else if (recall_hit) begin
          fire_rc = 1'b1;
          pos_nxt = '0;
        end else if (first_hit) begin
          pos_nxt = ONE;
        end else begin
          pos_nxt = '0;
        end
      end
    end
  end

  assign arm = fire_st | fire_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      pos      <= pos_nxt;
      store_q  <= fire_st;
      recall_q <= fire_rc;
    end
  end

  // R11: position holds without an accepted event
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pos));

  // R6: a write always clears the run, no command
  p_write_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_read) |=> (pos == '0 && !store_q && !recall_q));

  // R7: a first-entry read always leaves position 1
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_read && first_hit) |=> (pos == ONE));

  // R10: pulses exclusive and single-cycle
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_q && recall_q));
  p_store_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |=> !store_q);
  p_recall_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |=> !recall_q);

  // R4 / R5: a command leaves the position cleared
  p_cmd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_q || recall_q) |-> (pos == '0));
endmodule

// File: rtl/nvseq_lock.sv
module nvseq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic op_done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy <= 1'b0;
    else if (arm)            busy <= 1'b1;
    else if (busy && op_done) busy <= 1'b0;
  end

  // R8: lock set by a command, held until completion
  p_arm_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy);
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);
  p_lock_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);
endmodule

// File: rtl/nvseq_cmd_detect.sv
module nvseq_cmd_detect
  import nvseq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int KW    = CMP_W,
  parameter int N_SEQ = SEQ_LEN,
  localparam int PW   = $clog2(N_SEQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  output logic          cyc_ready,
  input  logic [AW-1:0] cyc_addr,
  input  logic          cyc_we_n,
  input  logic          supply_low,
  input  logic          op_done,
  output logic          store_cmd,
  output logic          recall_cmd,
  output logic [PW-1:0] match_pos
);
  logic             busy, take, arm;
  logic [N_SEQ-2:0] prefix_hit;
  logic             first_hit, store_hit, recall_hit;

  assign cyc_ready = !busy;
  assign take      = cyc_valid && cyc_ready;

  nvseq_addr_match #(.KEY_W(KW), .N_SEQ(N_SEQ)) u_match (
    .key        (cyc_addr[KW-1:0]),
    .prefix_hit (prefix_hit),
    .first_hit  (first_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit)
  );

  nvseq_tracker #(.N_SEQ(N_SEQ), .PW(PW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .is_read    (cyc_we_n),
    .prefix_hit (prefix_hit),
    .first_hit  (first_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit),
    .supply_low (supply_low),
    .pos        (match_pos),
    .arm        (arm),
    .store_q    (store_cmd),
    .recall_q   (recall_cmd)
  );

  nvseq_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .op_done (op_done),
    .busy    (busy)
  );

  // R9: completed store under low supply gives no store
  p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cyc_we_n && supply_low && match_pos == PW'(N_SEQ - 1))
    |=> !store_cmd);

  // R8: nothing is issued while locked
  p_no_cmd_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_ready |=> (!store_cmd && !recall_cmd));

  // R8: a command pulse coincides with the lock
  p_cmd_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd || recall_cmd) |-> !cyc_ready);
endmodule

// File: tb/test_nvseq_cmd_detect.sv
`timescale 1ns/1ps
module test_nvseq_cmd_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        cyc_ready;
  logic [14:0] cyc_addr = '0;
  logic        cyc_we_n = 1'b1;
  logic        supply_low = 1'b0;
  logic        op_done = 1'b0;
  logic        store_cmd, recall_cmd;
  logic [2:0]  match_pos;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int  m_pos = 0;
  bit  m_busy = 0;
  bit  m_st = 0;
  bit  m_rc = 0;
  int  seq_tab [6] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F, 'h0FC0};

  always #4 clk = ~clk;

  nvseq_cmd_detect i_nvseq_cmd_detect (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_addr(cyc_addr), .cyc_we_n(cyc_we_n), .supply_low(supply_low),
    .op_done(op_done), .store_cmd(store_cmd), .recall_cmd(recall_cmd),
    .match_pos(match_pos)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit v, input int a, input bit rd, input bit dn, input bit low);
    int k;
    k = a & 'h3FFF;
    m_st = 0;
    m_rc = 0;
    if (v && !m_busy) begin
      if (!rd) m_pos = 0;
      else if (m_pos < 5 && k == seq_tab[m_pos]) m_pos = m_pos + 1;
      else if (m_pos == 5 && k == 'h0FC0 && !low) begin m_st = 1; m_busy = 1; m_pos = 0; end
      else if (m_pos == 5 && k == 'h0C63) begin m_rc = 1; m_busy = 1; m_pos = 0; end
      else m_pos = (k == 'h0E38) ? 1 : 0;
    end else if (m_busy && dn) begin
      m_busy = 0;
    end
  endtask

  task automatic step(input bit v, input int a, input bit rd, input bit dn,
                      input bit low, input string tag);
    @(negedge clk);
    cyc_valid = v; cyc_addr = 15'(a); cyc_we_n = rd; op_done = dn; supply_low = low;
    #1;
    chk(tag, "ready", int'(cyc_ready), int'(!m_busy));
    @(posedge clk);
    model_edge(v, a, rd, dn, low);
    #2;
    chk(tag, "pos", int'(match_pos), m_pos);
    chk(tag, "store", int'(store_cmd), int'(m_st));
    chk(tag, "recall", int'(recall_cmd), int'(m_rc));
  endtask

  task automatic rd(input int a, input string tag);
    step(1, a, 1, 0, 0, tag);
  endtask

  task automatic prefix(input int top, input string tag);
    for (int i = 0; i < 5; i++) rd(seq_tab[i] | (((i % 2) == 1) ? top : 0), tag);
  endtask

  task automatic idle(input int n, input bit dn, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, dn, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pos", int'(match_pos), 0);
    chk("R1", "store", int'(store_cmd), 0);
    chk("R1", "recall", int'(recall_cmd), 0);
    chk("R1", "ready", int'(cyc_ready), 1);
    rst_n = 1'b1;

    // R2 + R4: full store run
    prefix(0, "R2");
    rd('h0FC0, "R4");
    // R8: offered cycles during lock are dropped
    rd('h0E38, "R8");
    rd('h31C7, "R8");
    idle(2, 0, "R8");
    idle(1, 1, "R8");
    rd('h0E38, "R8");
    step(1, 'h1234, 1, 0, 0, "R7");

    // R3 + R5: recall run with bit 14 set on some entries
    prefix('h4000, "R3");
    step(1, 'h4C63, 1, 0, 1, "R5");
    idle(1, 1, "R8");
    // R8: done without pending command has no effect
    idle(2, 1, "R8");

    // R6: write aborts mid run, even at a sequence address
    prefix(0, "R2");
    step(1, 'h0C63, 0, 0, 0, "R6");
    rd('h0C63, "R6");
    rd('h0E38, "R6");
    rd('h31C7, "R6");
    step(1, 'h03E0, 0, 0, 0, "R6");

    // R7: mismatch aborts; 0E38 restarts at one
    rd('h0E38, "R7");
    rd('h31C7, "R7");
    rd('h0E38, "R7");
    rd('h31C7, "R7");
    rd('h03E0, "R7");
    rd('h0E39, "R7");
    prefix(0, "R7");
    rd('h0E38, "R7");
    rd('h0E38, "R7");

    // R11: idle gaps inside a run
    for (int i = 1; i < 5; i++) begin
      rd(seq_tab[i], "R11");
      idle(3, 0, "R11");
    end
    rd('h0FC0, "R11");
    idle(1, 1, "R11");

    // R9: low supply blocks store, not recall
    prefix(0, "R9");
    step(1, 'h0FC0, 1, 0, 1, "R9");
    rd('h0FC0, "R9");
    prefix(0, "R9");
    step(1, 'h0C63, 1, 0, 1, "R9");
    idle(2, 0, "R9");
    idle(1, 1, "R9");

    // R10: back-to-back commands stay single pulses
    prefix(0, "R10");
    rd('h0C63, "R10");
    idle(1, 1, "R10");
    prefix(0, "R10");
    rd('h0FC0, "R10");
    idle(1, 1, "R10");
    // position 5 mismatch with 0E38 restarts
    prefix(0, "R7");
    rd('h0E38, "R7");
    idle(2, 0, "R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule